// File: doc/BRIEF.md
# Constant Fill DMA Engine

This unit executes one kind of DMA command: it fills a memory region with a repeated byte. A command queue presents a 16-byte packet: a 32-bit header, a target address, a source data word and an element count. The unit accepts the packet only while it is idle. It works out the region length from the element count and the element size given in the header. It then issues write bursts in which every byte carries the low byte of the source data word.

A select input tells the unit whether the target is device memory or host memory. For device memory, the region is cut into bursts so that no burst crosses a page boundary, and the page size is a parameter. A host-memory region goes out as one burst. After the final burst is accepted, the unit raises a one-cycle done pulse and moves its queue read pointer forward by one packet, so the queue can decode the next command.

Top module: `cfill_engine`

## Requirements
- R1: Header decode uses only bits 31:30 (element size as log2 of bytes) and bits 17:16 (swap code). Bits 15:0 (opcode and sub-opcode) and the reserved bits 29:18 do not change the writes.
- R2: The total number of bytes written for a packet is (count + 1) << size, and every burst has a nonzero length.
- R3: Every burst carries `wr_byte` equal to bits 7:0 of the packet's source data word.
- R4: For a device target, each burst starts where the previous one ended. Its length is the smaller of the distance to the next PAGE_BYTES boundary and the bytes still remaining, so no burst crosses a page boundary.
- R5: Only the final burst of a packet has `wr_last` high.
- R6: For a host target, the whole region is one burst at the packet address with `wr_last` high.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_len` hold their values.
- R8: `done` is high for exactly one cycle, in the cycle after the final burst is accepted. In the cycle after `done`, `rptr` has grown by 16.
- R9: `fill_swap` shows the swap code of the packet that was last accepted, and the swap code does not change `wr_byte`.
- R10: `pkt_valid` is ignored while `busy` is high: no extra bursts are produced and the current packet's bursts are unchanged.
- R11: After reset, `busy`, `wr_valid` and `done` are low, and `rptr` and `fill_swap` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Packet present; taken when idle |
| pkt_header | input | 32 | Packet header word |
| pkt_addr | input | ADDR_W | Region start address |
| pkt_data | input | 32 | Source data word; low byte is the fill value |
| pkt_count | input | CNT_W | Element count minus one |
| to_device | input | 1 | 1: device memory target, 0: host memory target |
| busy | output | 1 | A packet is in progress |
| wr_valid | output | 1 | Write burst request |
| wr_ready | input | 1 | Burst accepted when high with wr_valid |
| wr_addr | output | ADDR_W | Burst start address |
| wr_len | output | LEN_W | Burst length in bytes |
| wr_byte | output | 8 | Byte value repeated over the burst |
| wr_last | output | 1 | Final burst of the packet |
| done | output | 1 | One-cycle completion pulse |
| rptr | output | PTR_W | Queue read pointer in bytes |
| fill_swap | output | 2 | Swap code of the last accepted packet |

## Verification
The hardest case to reach is a device burst that starts just below a page boundary while the memory side is applying backpressure. Here the split length must stay stable over several stalled cycles and must then continue at the boundary. The stimulus starts regions at offsets 0xF00 and 0xFFE and uses element sizes up to 8 bytes. It toggles `wr_ready` in a fixed pattern, so stalls land in the middle of a split. A region that ends exactly on a boundary checks that no zero-length burst follows. A second packet driven while the first is still busy checks that it is dropped.

// File: rtl/cfill_pkg.sv
package cfill_pkg;

    localparam int HDR_W     = 32;
    localparam int PKT_BYTES = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } fill_state_e;

    typedef struct packed {
        logic [1:0] size_log2;
        logic [1:0] swap;
    } fill_hdr_t;

    function automatic fill_hdr_t split_header(input logic [HDR_W-1:0] h);
        fill_hdr_t f;
        f.size_log2 = h[31:30];
        f.swap      = h[17:16];
        return f;
    endfunction

endpackage

// File: rtl/cfill_decode.sv
module cfill_decode
    import cfill_pkg::*;
#(
    parameter int CNT_W = 22,
    parameter int LEN_W = CNT_W + 4
) (
    input  logic [HDR_W-1:0] header,
    input  logic [CNT_W-1:0] count,
    output fill_hdr_t        fields,
    output logic [LEN_W-1:0] total_len
);
    logic [LEN_W-1:0] elems;

    always_comb begin
        fields    = split_header(header);
        elems     = LEN_W'(count) + LEN_W'(1);
        total_len = elems << fields.size_log2;
    end
endmodule

// File: rtl/cfill_chunker.sv
module cfill_chunker #(
    parameter int ADDR_W     = 48,
    parameter int LEN_W      = 26,
    parameter int PAGE_BYTES = 4096
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [LEN_W-1:0]  remain,
    input  logic              split_pages,
    output logic [LEN_W-1:0]  chunk_len,
    output logic              chunk_last
);
    localparam int PG_W = $clog2(PAGE_BYTES);

    logic [LEN_W-1:0] room;

    generate
        if (PG_W == 0) begin : g_no_page
            assign room = LEN_W'(1);
        end else begin : g_page
            assign room = LEN_W'(PAGE_BYTES) - LEN_W'(cur_addr[PG_W-1:0]);
        end
    endgenerate

    always_comb begin
        if (split_pages && (room < remain)) chunk_len = room;
        else                                chunk_len = remain;
        chunk_last = (chunk_len == remain);
    end
endmodule

// File: rtl/cfill_engine.sv
module cfill_engine
    import cfill_pkg::*;
#(
    parameter int ADDR_W     = 48,
    parameter int CNT_W      = 22,
    parameter int PTR_W      = 32,
    parameter int PAGE_BYTES = 4096,
    parameter int LEN_W      = CNT_W + 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_valid,
    input  logic [31:0]       pkt_header,
    input  logic [ADDR_W-1:0] pkt_addr,
    input  logic [31:0]       pkt_data,
    input  logic [CNT_W-1:0]  pkt_count,
    input  logic              to_device,
    output logic              busy,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [LEN_W-1:0]  wr_len,
    output logic [7:0]        wr_byte,
    output logic              wr_last,
    output logic              done,
    output logic [PTR_W-1:0]  rptr,
    output logic [1:0]        fill_swap
);
    localparam int PG_W = $clog2(PAGE_BYTES);

    fill_state_e       state;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  remain;
    logic [7:0]        fill_byte;
    logic              dev_q;
    logic [1:0]        swap_q;

    fill_hdr_t         hdr;
    logic [LEN_W-1:0]  total_len;
    logic [LEN_W-1:0]  chunk_len;
    logic              chunk_last;

    cfill_decode #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_decode (
        .header    (pkt_header),
        .count     (pkt_count),
        .fields    (hdr),
        .total_len (total_len)
    );

    cfill_chunker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_chunk (
        .cur_addr    (cur_addr),
        .remain      (remain),
        .split_pages (dev_q),
        .chunk_len   (chunk_len),
        .chunk_last  (chunk_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur_addr  <= '0;
            remain    <= '0;
            fill_byte <= '0;
            dev_q     <= 1'b0;
            swap_q    <= '0;
            rptr      <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (pkt_valid) begin
                        cur_addr  <= pkt_addr;
                        remain    <= total_len;
                        fill_byte <= pkt_data[7:0];
                        dev_q     <= to_device;
                        swap_q    <= hdr.swap;
                        state     <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (wr_ready) begin
                        cur_addr <= cur_addr + ADDR_W'(chunk_len);
                        remain   <= remain - chunk_len;
                        if (chunk_last) state <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    rptr  <= rptr + PTR_W'(PKT_BYTES);
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        wr_valid  = (state == ST_ISSUE);
        wr_addr   = cur_addr;
        wr_len    = chunk_len;
        wr_last   = chunk_last;
        wr_byte   = fill_byte;
        done      = (state == ST_DONE);
        fill_swap = swap_q;
    end

    // R2: no empty bursts
    a_r2_len_nonzero: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_len != '0));

    // R4: device bursts stay inside one page
    a_r4_page_bound: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && dev_q) |->
            ((LEN_W'(wr_addr[PG_W-1:0]) + wr_len) <= LEN_W'(PAGE_BYTES)));

    // R6: host transfers are a single final burst
    a_r6_host_single: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !dev_q) |-> wr_last);

    // R7: request held under backpressure
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_len)));

    // R8: done follows the final accepted burst
    a_r8_done_after_last: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready && wr_last) |=> done);

    // R8: done lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: read pointer steps by one packet
    a_r8_ptr_step: assert property (@(posedge clk) disable iff (rst)
        done |=> (rptr == $past(rptr) + PTR_W'(PKT_BYTES)));

endmodule

// File: tb/tb_cfill_engine.sv
`timescale 1ns/1ps
module tb_cfill_engine;
    localparam int AW   = 48;
    localparam int CW   = 22;
    localparam int PW   = 32;
    localparam int PAGE = 4096;
    localparam int LW   = CW + 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pkt_valid = 1'b0;
    logic [31:0]   pkt_header = '0;
    logic [AW-1:0] pkt_addr = '0;
    logic [31:0]   pkt_data = '0;
    logic [CW-1:0] pkt_count = '0;
    logic          to_device = 1'b0;
    logic          busy, wr_valid, wr_last, done;
    logic          wr_ready = 1'b1;
    logic [AW-1:0] wr_addr;
    logic [LW-1:0] wr_len;
    logic [7:0]    wr_byte;
    logic [PW-1:0] rptr;
    logic [1:0]    fill_swap;

    always #2.5 clk = ~clk;

    cfill_engine #(.ADDR_W(AW), .CNT_W(CW), .PTR_W(PW), .PAGE_BYTES(PAGE)) dut (
        .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_header(pkt_header),
        .pkt_addr(pkt_addr), .pkt_data(pkt_data), .pkt_count(pkt_count),
        .to_device(to_device), .busy(busy), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_len(wr_len),
        .wr_byte(wr_byte), .wr_last(wr_last), .done(done), .rptr(rptr),
        .fill_swap(fill_swap)
    );

    typedef struct {
        logic [AW-1:0] a;
        longint        l;
        logic [7:0]    b;
        logic          last;
    } beat_t;

    beat_t expq[$];
    int total_checks = 0;
    int bad = 0;
    int ndone = 0;
    int pkts = 0;
    bit pending_done = 0;
    int ready_mode = 0;
    int cyc = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total_checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #1;
        cyc++;
        wr_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    end

    // monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                check(pending_done, "R8", "done without final burst", 1, 0);
                ndone++;
            end else if (pending_done) begin
                check(1'b0, "R8", "done missing", 0, 1);
            end
            pending_done = 0;
            if (wr_valid && wr_ready) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R10", "unexpected burst addr", longint'(wr_addr), 0);
                end else begin
                    beat_t e;
                    e = expq.pop_front();
                    check(wr_addr == e.a, "R4", "burst addr", longint'(wr_addr), longint'(e.a));
                    check(longint'(wr_len) == e.l, "R2", "burst len", longint'(wr_len), e.l);
                    check(wr_byte == e.b, "R3", "fill byte", longint'(wr_byte), longint'(e.b));
                    check(wr_last == e.last, "R5", "last flag", longint'(wr_last), longint'(e.last));
                    if (e.last) pending_done = 1;
                end
            end
        end
    end

    // driver
    task automatic send(input logic [AW-1:0] addr, input int count, input int fs,
                        input logic [31:0] data, input bit dev, input logic [1:0] swap,
                        input logic [11:0] rsv, input logic [15:0] opf, input bit poke);
        longint total, rem, room, l;
        logic [AW-1:0] a;
        while (busy) @(negedge clk);
        pkt_header = {fs[1:0], rsv, swap, opf};
        pkt_addr   = addr;
        pkt_data   = data;
        pkt_count  = CW'(count);
        to_device  = dev;
        total = longint'(count + 1) << fs;
        if (!dev) begin
            expq.push_back('{addr, total, data[7:0], 1'b1});
        end else begin
            a = addr; rem = total;
            while (rem > 0) begin
                room = PAGE - longint'(a % PAGE);
                l = (room < rem) ? room : rem;
                rem -= l;
                expq.push_back('{a, l, data[7:0], (rem == 0)});
                a += AW'(l);
            end
        end
        pkt_valid = 1'b1;
        @(negedge clk);
        pkt_valid = 1'b0;
        pkts++;
        if (poke) begin
            pkt_addr  = 48'h0DEAD000;
            pkt_count = CW'(7);
            pkt_data  = 32'h11;
            pkt_valid = 1'b1;
            repeat (2) @(negedge clk);
            pkt_valid = 1'b0;
        end
        while (ndone < pkts) @(negedge clk);
        @(negedge clk);
        check(rptr == PW'(16 * pkts), "R8", "read pointer", longint'(rptr), longint'(16 * pkts));
        check(fill_swap == swap, "R9", "swap field", longint'(fill_swap), longint'(swap));
        check(expq.size() == 0, "R10", "leftover bursts", expq.size(), 0);
        check(!busy, "R10", "busy after done", longint'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(!busy && !wr_valid && !done, "R11", "idle outputs",
              longint'({busy, wr_valid, done}), 0);
        check(rptr == '0 && fill_swap == '0, "R11", "pointer and swap",
              longint'(rptr), 0);
        rst = 1'b0;
        @(negedge clk);
        // R2 single byte
        send(48'h1000, 0, 0, 32'h0000_00A5, 1, 2'd0, 12'h0, 16'h000B, 0);
        // R4 split across boundary
        send(48'h0FFE, 3, 0, 32'h0000_0033, 1, 2'd1, 12'h0, 16'h000B, 0);
        // R4 unaligned start, 4-byte elements
        ready_mode = 1;
        send(48'h0F00, 1023, 2, 32'h0000_007E, 1, 2'd0, 12'h0, 16'h000B, 0);
        // R4 four full pages, 8-byte elements, backpressure R7
        send(48'h2000, 2047, 3, 32'h0000_00C3, 1, 2'd2, 12'h0, 16'h000B, 0);
        // R6 host region crossing pages stays one burst
        send(48'h0F00, 1023, 2, 32'h0000_0019, 0, 2'd0, 12'h0, 16'h000B, 0);
        // R9 swap code does not alter data; R1 reserved and opcode bits ignored
        ready_mode = 0;
        send(48'h5FF0, 31, 1, 32'hABCD_EF5A, 1, 2'd3, 12'hFFF, 16'hFFFF, 0);
        // R4 region ending exactly on a boundary
        send(48'h3F00, 255, 0, 32'h0000_0001, 1, 2'd0, 12'h0, 16'h000B, 0);
        // R10 packet during busy is ignored
        ready_mode = 1;
        send(48'h7FFC, 15, 0, 32'h0000_0066, 1, 2'd1, 12'h0, 16'h000B, 1);
        repeat (5) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total_checks, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total_checks++;
        bad++;
        $display("FAIL R8 watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total_checks, bad);
        $finish;
    end
endmodule